// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block produces a pulse-width-modulated output from a free-running up-counter. Software writes a 10-bit period and a 10-bit duty value. Each value is split into an 8-bit low byte and a 2-bit high part. A shared high-bits register holds both high parts. The counter advances on prescaled ticks and wraps after reaching the period. The output is in its active phase from count 0 through the duty count.

New duty values are double-buffered. A write only updates a master copy. The working (slave) copy takes the new value when the counter wraps, or when counting restarts. Because of this, a duty change never cuts the current period short. A period change leaves the running duty alone, so the absolute active time is kept while the frequency changes.

Explicit rules cover the corner cases:
- A duty equal to the period holds the output active.
- A zero duty holds it inactive.
- A polarity input picks which pin level counts as active.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset all registers, the counter and the slave duty are zero, and `pwm_o` sits at the inactive level (`!pol`).
- R2: The period is P = {hi[3:2], period low byte}. One PWM cycle lasts P+1 ticks: the counter steps 0..P and returns to 0 on the tick after reaching P.
- R3: The duty is D = {hi[1:0], duty low byte}. For a nonzero D, the output is active while the count is at most D, that is for D+1 ticks per cycle starting at count 0. The output register adds one clock of latency.
- R4: A duty write changes only the master copy. The slave copy that drives the compare takes the master value only at a counter wrap or at a restart.
- R5: Writing only the period leaves the slave duty unchanged, so the active time per cycle stays D+1 ticks.
- R6: When D equals P and is nonzero, the output is held active for the whole cycle.
- R7: When D is zero, the output is held inactive.
- R8: `ck_sel` picks the tick rate: 0 gives every clock, 1 gives every 2nd clock, 2 gives every 8th clock, and 3 gives one tick per clock in which `ext_tick` is high.
- R9: With `run` low, the counter holds and the output is inactive. In the clock where `run` rises, the counter and the prescaler are cleared and the slave duty is loaded from the master.
- R10: With `pwm_en` low, the output is inactive while the counter keeps running.
- R11: `pwm_o` equals the internal active flag when `pol` is 1, and its inverse when `pol` is 0. A change of `pol` is seen at once.
- R12: If the period is lowered below the current count, the counter returns to 0 on its next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_per_lo | input | 1 | Write strobe for the period low byte |
| wr_duty_lo | input | 1 | Write strobe for the duty low byte (master copy) |
| wr_hi | input | 1 | Write strobe for the high-bits register: bits 3:2 are the period high part, bits 1:0 the duty high part |
| wr_data | input | LO_W | Write data shared by the three strobes |
| pol | input | 1 | Active level of the duty phase |
| ck_sel | input | 2 | Tick source select |
| ext_tick | input | 1 | Alternate tick qualifier, used when `ck_sel` is 3 |
| pwm_en | input | 1 | Output enable |
| run | input | 1 | 0 stops the counter; a rising edge clears it and starts it |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with LO_W=8, HI_W=2, DIV_A=2 and DIV_B=8, which are the full 10-bit range and the defaults. This lets one scenario sweep a maximum-length 1024-tick cycle, with a duty that uses the high bits. The small divide ratios make every tick rate, including the gated alternate tick, observable within a few hundred clocks. A per-clock reference model predicts the active flag. That allows checks of mid-cycle duty writes, a lowered period overtaking the count, and restart loading of the newest duty on every clock, not only at cycle edges.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Tick source selection
  typedef enum logic [1:0] {
    CK_DIV1  = 2'd0,
    CK_DIV_A = 2'd1,
    CK_DIV_B = 2'd2,
    CK_EXT   = 2'd3
  } ck_sel_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int LO_W = 8,
  parameter int HI_W = 2,
  localparam int CNT_W = LO_W + HI_W,
  localparam int HR_W  = 2 * HI_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_per_lo,
  input  logic             wr_duty_lo,
  input  logic             wr_hi,
  input  logic [LO_W-1:0]  wr_data,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] duty_mst
);

  logic [LO_W-1:0] per_lo_q;
  logic [LO_W-1:0] duty_lo_q;
  logic [HR_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_lo_q  <= '0;
      duty_lo_q <= '0;
      hi_q      <= '0;
    end else begin
      if (wr_per_lo)  per_lo_q  <= wr_data;
      if (wr_duty_lo) duty_lo_q <= wr_data;
      if (wr_hi)      hi_q      <= wr_data[HR_W-1:0];
    end
  end

  // upper half of the high register extends the period, lower half the duty
  assign period   = {hi_q[HR_W-1:HI_W], per_lo_q};
  assign duty_mst = {hi_q[HI_W-1:0], duty_lo_q};

  AST_DUTY_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_duty_lo |=> duty_mst[LO_W-1:0] == $past(wr_data)); // R4

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_pkg::*;
#(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  localparam int DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B,
  localparam int PRE_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1
) (
  input  logic    clk,
  input  logic    rst,
  input  ck_sel_e sel,
  input  logic    counting,
  input  logic    restart,
  input  logic    ext_tick,
  output logic    tick_o
);

  localparam logic [PRE_W-1:0] LIM_A = PRE_W'(DIV_A - 1);
  localparam logic [PRE_W-1:0] LIM_B = PRE_W'(DIV_B - 1);

  logic [PRE_W-1:0] pre_q;
  logic             hit;
  logic             divided;

  // terminal count of the divider chosen by the select code
  function automatic logic [PRE_W-1:0] limit_of(input ck_sel_e s);
    return (s == CK_DIV_B) ? LIM_B : LIM_A;
  endfunction

  always_comb begin
    unique case (sel)
      CK_DIV1:  hit = 1'b1;
      CK_DIV_A,
      CK_DIV_B: hit = (pre_q == limit_of(sel));
      default:  hit = ext_tick;
    endcase
  end

  assign divided = (sel == CK_DIV_A) || (sel == CK_DIV_B);
  assign tick_o  = counting & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (restart || !counting || !divided || hit) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  AST_DIV_A_SPACING: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == CK_DIV_A && sel == CK_DIV_A && $past(tick_o)) |-> !tick_o); // R8
  AST_EXT_GATED: assert property (@(posedge clk) disable iff (rst)
    (sel == CK_EXT && !ext_tick) |-> !tick_o); // R8

endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start_evt,
  input  logic             counting,
  input  logic             drive_en,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty_mst,
  output logic             act_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] slave_q;
  logic             wrap;
  logic             load_slave;

  // next count: return to zero at or beyond the period, otherwise step
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] p);
    return (c >= p) ? '0 : c + 1'b1;
  endfunction

  // active phase: nonzero duty and count not past it
  function automatic logic in_duty(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] d);
    return (d != '0) && (c <= d);
  endfunction

  assign wrap       = tick && (cnt_q >= period);
  assign load_slave = start_evt || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      slave_q <= '0;
      act_o   <= 1'b0;
    end else begin
      if (start_evt)  cnt_q <= '0;
      else if (tick)  cnt_q <= step_count(cnt_q, period);
      if (load_slave) slave_q <= duty_mst;
      act_o <= drive_en && counting && in_duty(cnt_q, slave_q);
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt_q == '0); // R12
  AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_slave |=> $stable(slave_q)); // R4
  AST_ZERO_DUTY_OFF: assert property (@(posedge clk) disable iff (rst)
    (slave_q == '0) |=> !act_o); // R7
  AST_FULL_DUTY_ON: assert property (@(posedge clk) disable iff (rst)
    (drive_en && counting && slave_q != '0 && slave_q == period && cnt_q <= period)
      |=> act_o); // R6
  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (rst)
    !drive_en |=> !act_o); // R10
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!counting && !start_evt) |=> ($stable(cnt_q) && !act_o)); // R9
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (cnt_q == '0 && slave_q == $past(duty_mst))); // R9

endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf
  import pwm_pkg::*;
#(
  parameter int LO_W  = 8,
  parameter int HI_W  = 2,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_per_lo,
  input  logic            wr_duty_lo,
  input  logic            wr_hi,
  input  logic [LO_W-1:0] wr_data,
  input  logic            pol,
  input  logic [1:0]      ck_sel,
  input  logic            ext_tick,
  input  logic            pwm_en,
  input  logic            run,
  output logic            pwm_o
);

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] duty_mst;
  logic             run_q;
  logic             start_evt;
  logic             counting;
  logic             tick;
  logic             act;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= run;
  end

  assign start_evt = run & ~run_q;
  assign counting  = run & run_q;

  pwm_regs #(.LO_W(LO_W), .HI_W(HI_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_per_lo  (wr_per_lo),
    .wr_duty_lo (wr_duty_lo),
    .wr_hi      (wr_hi),
    .wr_data    (wr_data),
    .period     (period),
    .duty_mst   (duty_mst)
  );

  pwm_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .sel      (ck_sel_e'(ck_sel)),
    .counting (counting),
    .restart  (start_evt),
    .ext_tick (ext_tick),
    .tick_o   (tick)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .start_evt (start_evt),
    .counting  (counting),
    .drive_en  (pwm_en),
    .period    (period),
    .duty_mst  (duty_mst),
    .act_o     (act)
  );

  assign pwm_o = pol ? act : ~act;

  AST_START_NEEDS_STOP: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> !tick); // R9
  AST_RESET_INACTIVE: assert property (@(posedge clk)
    $past(rst) |-> (pwm_o == ~pol)); // R1

endmodule

// File: tb/sim_pwm_dbuf.sv
module sim_pwm_dbuf;

  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_per_lo = 1'b0, wr_duty_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic       pol = 1'b1;
  logic [1:0] ck_sel = 2'd0;
  logic       ext_tick = 1'b0;
  logic       pwm_en = 1'b0;
  logic       run = 1'b0;
  logic       pwm_o;

  pwm_dbuf #(.LO_W(8), .HI_W(2), .DIV_A(2), .DIV_B(8)) u0 (
    .clk(clk), .rst(rst), .wr_per_lo(wr_per_lo), .wr_duty_lo(wr_duty_lo),
    .wr_hi(wr_hi), .wr_data(wr_data), .pol(pol), .ck_sel(ck_sel),
    .ext_tick(ext_tick), .pwm_en(pwm_en), .run(run), .pwm_o(pwm_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";
  bit    exp_q[$];
  string tag_q[$];
  int    sh_hi = 0;

  // reference state, written from the requirements
  bit m_run;
  int m_pre, m_cnt, m_slave, m_plo, m_dlo, m_hi;
  bit m_act;

  always @(posedge clk) begin : ref_model
    int per, mst;
    bit strt, live, hit, nxt;
    if (rst) begin
      m_run = 0; m_pre = 0; m_cnt = 0; m_slave = 0;
      m_plo = 0; m_dlo = 0; m_hi = 0; m_act = 0;
    end else begin
      per  = ((m_hi >> 2) & 3) * 256 + m_plo;   // R2
      mst  = (m_hi & 3) * 256 + m_dlo;          // R3
      strt = run && !m_run;
      live = run && m_run;
      case (ck_sel)
        2'd0: hit = 1;
        2'd1: hit = (m_pre == 1);
        2'd2: hit = (m_pre == 7);
        default: hit = ext_tick;
      endcase
      nxt = pwm_en && live && (m_slave != 0) && (m_cnt <= m_slave);
      if (strt) begin
        m_cnt = 0; m_slave = mst;
      end else if (live && hit) begin
        if (m_cnt >= per) begin m_cnt = 0; m_slave = mst; end
        else m_cnt = m_cnt + 1;
      end
      if (live && (ck_sel == 2'd1 || ck_sel == 2'd2) && !hit) m_pre = m_pre + 1;
      else m_pre = 0;
      if (wr_per_lo)  m_plo = wr_data;
      if (wr_duty_lo) m_dlo = wr_data;
      if (wr_hi)      m_hi  = wr_data & 15;
      m_run = run;
      m_act = nxt;
    end
    exp_q.push_back(m_act);
    tag_q.push_back(cur_tag);
  end

  // monitor: compare the pin with the predicted active flag, mapped by pol (R11)
  always @(negedge clk) begin : monitor
    bit    e;
    bit    lvl;
    string t;
    if (exp_q.size() > 0) begin
      e   = exp_q.pop_front();
      t   = tag_q.pop_front();
      lvl = pol ? e : !e;
      checks++;
      if (pwm_o !== lvl) begin
        errors++;
        $display("FAIL %s pwm_o=%b expected %b at %0t", t, pwm_o, lvl, $time);
      end
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input int kind, input int v);
    @(negedge clk);
    wr_data    = 8'(v);
    wr_per_lo  = (kind == 0);
    wr_duty_lo = (kind == 1);
    wr_hi      = (kind == 2);
    @(negedge clk);
    wr_per_lo = 0; wr_duty_lo = 0; wr_hi = 0;
  endtask

  task automatic set_period(input int p);
    reg_write(0, p & 255);
    sh_hi = (sh_hi & 3) | (((p >> 8) & 3) << 2);
    reg_write(2, sh_hi);
  endtask

  task automatic set_duty(input int d);
    reg_write(1, d & 255);
    sh_hi = (sh_hi & 12) | ((d >> 8) & 3);
    reg_write(2, sh_hi);
  endtask

  task automatic direct_check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    logic [7:0] lf;
    wait_clks(4);
    rst = 0;
    @(negedge clk);
    direct_check(pwm_o === !pol, "R1", pwm_o, !pol);
    pol = 0;
    #1;
    direct_check(pwm_o === 1'b1, "R1", pwm_o, 1);
    pol = 1;

    cur_tag = "R2";
    set_period(9);
    set_duty(3);
    @(negedge clk); pwm_en = 1; run = 1;
    wait_clks(45);

    cur_tag = "R4";
    wait_clks(3);
    set_duty(6);
    wait_clks(30);

    cur_tag = "R5";
    set_period(20);
    wait_clks(60);

    cur_tag = "R6";
    set_duty(20);
    wait_clks(50);

    cur_tag = "R7";
    set_duty(0);
    wait_clks(50);

    cur_tag = "R8";
    set_period(5);
    set_duty(2);
    ck_sel = 2'd1; wait_clks(40);
    ck_sel = 2'd2; wait_clks(120);
    ck_sel = 2'd3;
    lf = 8'hA5;
    for (int i = 0; i < 100; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      ext_tick = lf[0];
      @(negedge clk);
    end
    ext_tick = 0;
    ck_sel = 2'd0;

    cur_tag = "R9";
    run = 0; wait_clks(20);
    set_duty(4);
    @(negedge clk); run = 1;
    wait_clks(30);

    cur_tag = "R10";
    pwm_en = 0; wait_clks(20);
    pwm_en = 1; wait_clks(20);

    cur_tag = "R11";
    pol = 0; wait_clks(40);
    pol = 1;

    cur_tag = "R12";
    set_period(30);
    set_duty(10);
    wait_clks(25);
    set_period(5);
    wait_clks(40);

    cur_tag = "R3";
    set_period(1023);
    set_duty(700);
    wait_clks(2200);

    wait_clks(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule